// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast clock by a programmable integer N and emits one single-cycle pulse per N input cycles, for use as the feedback input of a phase comparator. Inside, a prescaler counts each step either 33 or 32 input cycles long. A swallow count `swallow_cnt` (A, 0 to 31) and a main count `main_cnt` (B) decide how the steps are mixed. Each output period has B prescaler steps, and the first A of them are the long ones, so N = 32·B + A. A ≤ B must hold. Under that condition every ratio from 992 to 32767 can be reached, and so can many smaller ratios.

`hold` holds the divider at its load point. The prescaler phase is cleared and both counts track the inputs. When `hold` is released, counting starts on the next edge. The divider reads new A and B values only when it reloads at the end of a period, so a period is never made of two settings.

Top module: `swallow_divider`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `div_out` is low and the divider sits at its load point, the same as with `hold`.
- R2: For any 3 ≤ B ≤ 1023 and 0 ≤ A ≤ min(B,31), consecutive `div_out` pulses are exactly 32·B + A input cycles apart.
- R3: With A = 0, every prescaler step is 32 cycles long and the period is exactly 32·B.
- R4: With A = B, every prescaler step is 33 cycles long and the period is exactly 33·B.
- R5: `div_out` is high for exactly one input-clock cycle per period.
- R6: While `hold` is high, `div_out` stays low. Counting the first rising edge with `hold` low as edge 1, the first pulse is output after edge N.
- R7: A change of A or B in the middle of a period does not change that period. The new values set the length of the next full period.
- R8: The extreme settings B = 1023, A = 31 (N = 32767) and B = 31, A = 0 (N = 992) give exact periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Holds both counts at their load point while high |
| swallow_cnt | input | 5 | A: number of 33-cycle prescaler steps per period |
| main_cnt | input | 10 | B: total prescaler steps per period |
| div_out | output | 1 | One-cycle pulse per N input cycles |

## Verification
The bench counts input cycles between pulses and compares each count with 32·B + A. It uses random legal pairs with small B, plus the cases A = 0 and A = B. These two cases separate a fault in the 32-cycle step from a fault in the 33-cycle step. The two ends of the gap-free range check counter widths and terminal-count decoding. Changing the inputs mid-period shows whether the values are sampled at reload or continuously. The latency measured from `hold` release shows whether the counts restart cleanly at the load point.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int PRE = 32,
  parameter int AW  = 5,
  parameter int BW  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [AW-1:0] swallow_cnt,
  input  logic [BW-1:0] main_cnt,
  output logic          div_out
);
  localparam int PW = $clog2(PRE + 1);

  logic [PW-1:0] pcnt;
  logic [AW-1:0] a_rem;
  logic [BW-1:0] b_rem;
  logic          mc, pend, last;

  assign mc   = a_rem != '0;
  assign pend = pcnt == (mc ? PW'(PRE) : PW'(PRE - 1));
  assign last = b_rem <= BW'(1);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      pcnt    <= '0;
      a_rem   <= swallow_cnt;
      b_rem   <= main_cnt;
      div_out <= 1'b0;
    end else begin
      div_out <= pend && last;
      if (pend) begin
        pcnt <= '0;
        if (last) begin
          a_rem <= swallow_cnt;
          b_rem <= main_cnt;
        end else begin
          b_rem <= b_rem - BW'(1);
          if (mc) a_rem <= a_rem - AW'(1);
        end
      end else begin
        pcnt <= pcnt + PW'(1);
      end
    end
  end

  // R6: held divider never pulses
  a_r6_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    hold |=> !div_out);

  // R5: pulse lasts one input cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  // R2: a pulse coincides with the prescaler back at phase zero
  a_r2_pulse_at_reload: assert property (@(posedge clk) disable iff (rst)
    div_out |-> pcnt == '0);

  // R4: the long step only occurs while swallow steps remain
  a_r4_long_step_gated: assert property (@(posedge clk) disable iff (rst)
    (pcnt == PW'(PRE)) |-> a_rem != '0);

  // R2: prescaler phase never exceeds the long modulus
  a_r2_phase_bound: assert property (@(posedge clk) disable iff (rst)
    pcnt <= PW'(PRE));
endmodule

// File: tb/swallow_divider_bench.sv
module swallow_divider_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold = 1'b0;
  logic [4:0] a_in = '0;
  logic [9:0] b_in = 10'd3;
  logic div_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  swallow_divider u_swallow_divider (
    .clk(clk), .rst(rst), .hold(hold),
    .swallow_cnt(a_in), .main_cnt(b_in), .div_out(div_out)
  );

  function automatic int exp_n(input int a, input int b);
    return 32 * b + a;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!div_out && c < 40000);
  endtask

  task automatic start(input int a, input int b);
    @(negedge clk);
    a_in = 5'(a); b_in = 10'(b); hold = 1'b1;
    repeat (3) @(negedge clk);
    check(div_out == 1'b0, "R6 hold quiet", int'(div_out), 0);
    hold = 1'b0;
  endtask

  task automatic run_pair(input int a, input int b, input string tag);
    int c;
    start(a, b);
    wait_pulse(c);
    check(c == exp_n(a, b), {tag, " R6 first latency"}, c, exp_n(a, b));
    @(negedge clk);
    check(div_out == 1'b0, "R5 width", int'(div_out), 0);
    wait_pulse(c);
    check(c == exp_n(a, b) - 1, {tag, " period"}, c + 1, exp_n(a, b));
  endtask

  initial begin
    int c;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(div_out == 1'b0, "R1 reset low", int'(div_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check(div_out == 1'b0, "R1 after reset", int'(div_out), 0);

    run_pair(0, 50, "R3 A=0");
    run_pair(31, 31, "R4 A=B");
    run_pair(5, 5, "R4 A=B small");
    run_pair(0, 31, "R8 N=992");
    run_pair(3, 3, "R2 min B");

    for (int i = 0; i < 12; i++) begin
      int b, a;
      b = int'($urandom_range(3, 40));
      a = int'($urandom_range(0, (b < 31) ? b : 31));
      run_pair(a, b, "R2 random");
    end

    start(7, 20);
    wait_pulse(c);
    check(c == exp_n(7, 20), "R7 first", c, exp_n(7, 20));
    repeat (100) @(negedge clk);
    a_in = 5'd12; b_in = 10'd35;
    wait_pulse(c);
    check(c == exp_n(7, 20) - 100, "R7 old period kept", c + 100, exp_n(7, 20));
    wait_pulse(c);
    check(c == exp_n(12, 35), "R7 new period", c, exp_n(12, 35));

    start(31, 1023);
    wait_pulse(c);
    check(c == 32767, "R8 N=32767 latency", c, 32767);
    wait_pulse(c);
    check(c == 32767, "R8 N=32767 period", c, 32767);

    @(negedge clk);
    hold = 1'b1;
    for (int k = 0; k < 1200; k++) begin
      @(negedge clk);
      if (div_out) break;
    end
    check(div_out == 1'b0, "R6 long hold", int'(div_out), 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule